// File: doc/BRIEF.md
# DMA Partial-Line Write Coalescer

This block sits between address-translated DMA write requests and a memory port that only reads and writes whole cache lines. Devices send writes of one or two 16-byte chunks. Each write carries a per-mapping attribute that selects between two handling modes.

- **Streaming** writes are gathered in a single line buffer, in the hope that later writes complete the same line.
- **Consistent** writes are finished at once. If the line is not complete, the block reads it, merges the new bytes over it and writes it back.

A per-byte valid mask records which buffered bytes came from the device. When every byte of the line has been supplied, the line goes out as one write with no read. The buffered line is pushed out when any of these happens:

- a write for another line arrives,
- a consistent write arrives,
- the flush input is raised,
- the buffer has stayed idle too long.

While any memory sequence runs, the device side is stalled.

Top module: `wcoal_top`

## Requirements
- R1: After reset, `wrReady` is high, `memRdValid`, `memWrValid` and `wrErr` are low, and the buffer is empty.
- R2: An aligned streaming write to an empty buffer, or to the line already buffered, is accepted and held. No memory request is made while the line is still incomplete.
- R3: When the buffered bytes cover all LINE_BYTES bytes of the line, the line is sent as a single memory write with no memory read.
- R4: An accepted aligned consistent write that leaves the line incomplete starts, from the next cycle, a read of the line. Only bytes not supplied by the device take memory data. The merged line is written back before any further write is accepted.
- R5: A consistent write to the buffered line joins the bytes already held. The whole line is completed with one read and one write.
- R6: An aligned write whose line differs from the buffered line is stalled. The buffered line is flushed by read-merge-write first, and the new write is then accepted against an empty buffer.
- R7: A one-cycle `flushReq` pulse while a line is buffered and no sequence runs starts a read-merge-write of that line. With an empty buffer it causes no memory traffic.
- R8: If no write is accepted for IDLE_LIMIT consecutive cycles while a line is buffered, the line is flushed by read-merge-write.
- R9: A write is misaligned if its address bits below CHUNK_BYTES are not zero, or if its last chunk lies beyond the end of the line. A misaligned write is accepted and dropped, and `wrErr` is high in the following cycle only. Memory is not changed by it.
- R10: `wrReady` is low in every cycle in which a memory read is requested, awaited, or a memory write is requested.
- R11: `memRdValid` and `memWrValid` are never high together. Each stays high, with `memAddr` (and `memWrData` for writes) unchanged, until the matching ready is seen.
- R12: Data layout is as follows:
  - `wrSize` 0 means one chunk and 1 means two chunks.
  - Request byte i (`wrData[8i+7:8i]`) lands at line offset `wrAddr[5:0]`+i.
  - Line byte b is `memWrData`/`memRdData[8b+7:8b]`.
  - `memAddr` is the line address with its low 6 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Device write request valid |
| wrReady | output | 1 | Request accepted on a cycle with wrValid high |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrSize | input | SZ_W | Chunk count minus one |
| wrStream | input | 1 | 1 streaming, 0 consistent |
| wrData | input | MAX_CHUNKS*CHUNK_BYTES*8 | Write bytes, lowest byte first |
| wrErr | output | 1 | One-cycle flag for a dropped misaligned write |
| flushReq | input | 1 | Push out the buffered line |
| memRdValid | output | 1 | Line read request |
| memRdReady | input | 1 | Memory takes the read request |
| memRdDataValid | input | 1 | Read line data present |
| memRdData | input | LINE_BYTES*8 | Read line data |
| memWrValid | output | 1 | Line write request |
| memWrReady | input | 1 | Memory takes the write |
| memWrData | output | LINE_BYTES*8 | Line data to write |
| memAddr | output | ADDR_W | Line address for read or write |

## Verification
The bench keeps the default geometry: 64-byte lines, 16-byte chunks, up to two chunks per write and 40-bit addresses. Only IDLE_LIMIT is lowered to 32. This brings the idle-timeout flush within a few dozen cycles, so it can be checked to the cycle window directly. It also lets the timeout fire naturally in the random phase.

With only eight lines in the bench memory, random writes keep switching between streaming and consistent mode on the same few lines. This means repeatedly:
- filling lines completely,
- evicting on line changes,
- merging consistent writes into a held line.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;

  // Strobes from the sequencer to the line datapath.
  typedef struct packed {
    logic loadWr;    // merge the accepted device bytes into the buffer
    logic mergeMem;  // fill unwritten bytes from the memory read data
    logic clearBuf;  // line written out, buffer becomes empty
  } dpStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_WRITE = 2'd3
  } seqState_t;

endpackage

// File: rtl/wcoal_datapath.sv
module wcoal_datapath
  import wcoal_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  parameter int MAX_CHUNKS  = 2,
  localparam int SZ_W       = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int WR_W       = MAX_CHUNKS * CHUNK_BYTES * 8,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SZ_W-1:0]   wrSize,
  input  logic [WR_W-1:0]   wrData,
  input  logic [LINE_W-1:0] memRdData,
  output logic              aligned,
  output logic              tagHit,
  output logic              bufValid,
  output logic              willFull,
  output logic              bufFull,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWrData
);

  localparam int CHUNKS  = LINE_BYTES / CHUNK_BYTES;
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int COFF_W  = $clog2(CHUNK_BYTES);
  localparam int CIDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int CHUNK_W = CHUNK_BYTES * 8;

  logic [CIDX_W-1:0]     reqChunk;
  logic [TAG_W-1:0]      reqTag;
  int                    lastChunk;
  logic [CHUNKS-1:0]     chunkEn;
  logic [LINE_BYTES-1:0] byteEn;
  logic [CHUNK_W-1:0]    placedChunk [CHUNKS];
  logic [LINE_W-1:0]     placedLine;

  logic [LINE_W-1:0]     bufData;
  logic [LINE_BYTES-1:0] bufMask;
  logic [TAG_W-1:0]      bufTag;

  assign reqChunk  = wrAddr[OFF_W-1:COFF_W];
  assign reqTag    = wrAddr[ADDR_W-1:OFF_W];
  assign lastChunk = int'(reqChunk) + int'(wrSize);
  assign aligned   = (wrAddr[COFF_W-1:0] == '0) && (lastChunk < CHUNKS) &&
                     (int'(wrSize) < MAX_CHUNKS);

  // Steer the request chunks onto their line positions.
  for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
    assign chunkEn[k] = (k >= int'(reqChunk)) && (k <= lastChunk);
    assign byteEn[k*CHUNK_BYTES +: CHUNK_BYTES] = {CHUNK_BYTES{chunkEn[k]}};

    always_comb begin
      placedChunk[k] = '0;
      for (int j = 0; j < MAX_CHUNKS; j++) begin
        if (int'(reqChunk) + j == k) placedChunk[k] = wrData[j*CHUNK_W +: CHUNK_W];
      end
    end

    assign placedLine[k*CHUNK_W +: CHUNK_W] = placedChunk[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
      bufMask <= '0;
      bufTag  <= '0;
    end else if (strobe.clearBuf) begin
      bufMask <= '0;
    end else if (strobe.loadWr) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (byteEn[b]) bufData[b*8 +: 8] <= placedLine[b*8 +: 8];
      end
      bufMask <= bufMask | byteEn;
      bufTag  <= reqTag;
    end else if (strobe.mergeMem) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (!bufMask[b]) bufData[b*8 +: 8] <= memRdData[b*8 +: 8];
      end
      bufMask <= '1;
    end
  end

  assign bufValid  = |bufMask;
  assign bufFull   = &bufMask;
  assign tagHit    = bufValid && (bufTag == reqTag);
  assign willFull  = &(bufMask | byteEn);
  assign memAddr   = {bufTag, {OFF_W{1'b0}}};
  assign memWrData = bufData;

endmodule

// File: rtl/wcoal_ctrl.sv
module wcoal_ctrl
  import wcoal_pkg::*;
#(
  parameter int IDLE_LIMIT = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrValid,
  input  logic      wrStream,
  input  logic      flushReq,
  input  logic      aligned,
  input  logic      tagHit,
  input  logic      bufValid,
  input  logic      willFull,
  input  logic      bufFull,
  input  logic      memRdReady,
  input  logic      memRdDataValid,
  input  logic      memWrReady,
  output logic      wrReady,
  output logic      wrErr,
  output logic      memRdValid,
  output logic      memWrValid,
  output dpStrobe_t strobe
);

  localparam int CNT_W = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_LIMIT - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] idleCnt;
  logic             timeout, lineConflict, startFlush, accept, acceptOk;

  assign timeout      = bufValid && (idleCnt == CNT_LAST);
  assign lineConflict = wrValid && aligned && bufValid && !tagHit;
  assign startFlush   = (state == SEQ_IDLE) && bufValid &&
                        (flushReq || timeout || lineConflict);
  assign wrReady      = (state == SEQ_IDLE) && !startFlush;
  assign accept       = wrValid && wrReady;
  assign acceptOk     = accept && aligned;

  assign memRdValid   = (state == SEQ_READ);
  assign memWrValid   = (state == SEQ_WRITE);

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.loadWr   = acceptOk;
    unique case (state)
      SEQ_IDLE: begin
        if (startFlush)    stateNext = bufFull ? SEQ_WRITE : SEQ_READ;
        else if (acceptOk) begin
          if (willFull)       stateNext = SEQ_WRITE;
          else if (!wrStream) stateNext = SEQ_READ;
        end
      end
      SEQ_READ:  if (memRdReady) stateNext = SEQ_WAIT;
      SEQ_WAIT:  if (memRdDataValid) begin
        strobe.mergeMem = 1'b1;
        stateNext       = SEQ_WRITE;
      end
      SEQ_WRITE: if (memWrReady) begin
        strobe.clearBuf = 1'b1;
        stateNext       = SEQ_IDLE;
      end
      default:   stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      idleCnt <= '0;
      wrErr   <= 1'b0;
    end else begin
      state <= stateNext;
      wrErr <= accept && !aligned;
      if ((state != SEQ_IDLE) || !bufValid || accept) idleCnt <= '0;
      else if (idleCnt != CNT_LAST)                   idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/wcoal_top.sv
module wcoal_top
  import wcoal_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  parameter int MAX_CHUNKS  = 2,
  parameter int IDLE_LIMIT  = 256,
  localparam int SZ_W       = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int WR_W       = MAX_CHUNKS * CHUNK_BYTES * 8,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SZ_W-1:0]   wrSize,
  input  logic              wrStream,
  input  logic [WR_W-1:0]   wrData,
  output logic              wrErr,
  input  logic              flushReq,
  output logic              memRdValid,
  input  logic              memRdReady,
  input  logic              memRdDataValid,
  input  logic [LINE_W-1:0] memRdData,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [LINE_W-1:0] memWrData,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  dpStrobe_t strobe;
  logic      aligned, tagHit, bufValid, willFull, bufFull;

  wcoal_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrStream(wrStream),
    .flushReq(flushReq), .aligned(aligned), .tagHit(tagHit),
    .bufValid(bufValid), .willFull(willFull), .bufFull(bufFull),
    .memRdReady(memRdReady), .memRdDataValid(memRdDataValid),
    .memWrReady(memWrReady), .wrReady(wrReady), .wrErr(wrErr),
    .memRdValid(memRdValid), .memWrValid(memWrValid), .strobe(strobe)
  );

  wcoal_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrSize(wrSize), .wrData(wrData), .memRdData(memRdData),
    .aligned(aligned), .tagHit(tagHit), .bufValid(bufValid),
    .willFull(willFull), .bufFull(bufFull), .memAddr(memAddr),
    .memWrData(memWrData)
  );

endmodule

// File: rtl/wcoal_checker.sv
module wcoal_checker #(
  parameter int ADDR_W      = 40,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  parameter int SZ_W        = 1,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int COFF_W     = $clog2(CHUNK_BYTES),
  localparam int CHUNKS     = LINE_BYTES / CHUNK_BYTES
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrReady,
  input logic [OFF_W-1:0]  addrLow,
  input logic [SZ_W-1:0]   wrSize,
  input logic              wrStream,
  input logic              wrErr,
  input logic              memRdValid,
  input logic              memRdReady,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [LINE_W-1:0] memWrData,
  input logic [ADDR_W-1:0] memAddr
);

  logic misal, take;
  assign misal = (addrLow[COFF_W-1:0] != '0) ||
                 (int'(addrLow[OFF_W-1:COFF_W]) + int'(wrSize) >= CHUNKS);
  assign take  = wrValid && wrReady;

  a_r10_stall_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid || memWrValid) |-> !wrReady);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdValid && memWrValid));

  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> (memRdValid && $stable(memAddr)));

  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memAddr) && $stable(memWrData)));

  a_r9_err_raise: assert property (@(posedge clk) disable iff (!rstN)
    (take && misal) |=> wrErr);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(take && misal) |=> !wrErr);

  a_r4_consistent_now: assert property (@(posedge clk) disable iff (!rstN)
    (take && !misal && !wrStream) |=> (memRdValid || memWrValid));

  a_r12_line_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid || memWrValid) |-> (memAddr[OFF_W-1:0] == '0));

endmodule

bind wcoal_top wcoal_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .CHUNK_BYTES(CHUNK_BYTES), .SZ_W(SZ_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .addrLow(wrAddr[OFF_W-1:0]), .wrSize(wrSize), .wrStream(wrStream),
  .wrErr(wrErr), .memRdValid(memRdValid), .memRdReady(memRdReady),
  .memWrValid(memWrValid), .memWrReady(memWrReady),
  .memWrData(memWrData), .memAddr(memAddr)
);

// File: tb/tb_wcoal_top.sv
`timescale 1ns/1ps
module tb_wcoal_top;

  localparam int IDLE_LIMIT = 32;
  localparam int NLINES     = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic         wrReady;
  logic [39:0]  wrAddr = '0;
  logic [0:0]   wrSize = '0;
  logic         wrStream = 1'b0;
  logic [255:0] wrData = '0;
  logic         wrErr;
  logic         flushReq = 1'b0;
  logic         memRdValid;
  logic         memRdReady = 1'b0;
  logic         memRdDataValid = 1'b0;
  logic [511:0] memRdData = '0;
  logic         memWrValid;
  logic         memWrReady = 1'b0;
  logic [511:0] memWrData;
  logic [39:0]  memAddr;

  always #2 clk = ~clk;

  wcoal_top #(.IDLE_LIMIT(IDLE_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrSize(wrSize), .wrStream(wrStream), .wrData(wrData),
    .wrErr(wrErr), .flushReq(flushReq), .memRdValid(memRdValid),
    .memRdReady(memRdReady), .memRdDataValid(memRdDataValid),
    .memRdData(memRdData), .memWrValid(memWrValid), .memWrReady(memWrReady),
    .memWrData(memWrData), .memAddr(memAddr)
  );

  // Bench memory: eight lines at the bottom of the address space.
  logic [511:0] mem    [NLINES];
  logic [511:0] expMem [NLINES];
  int rdCount = 0, wrCount = 0, overlap = 0;
  logic       rdPend = 1'b0;
  int         rdDelay = 0;
  logic [2:0] rdLine = '0;

  always @(posedge clk) begin
    memRdReady     <= ($urandom_range(0, 3) != 0);
    memWrReady     <= ($urandom_range(0, 3) != 0);
    memRdDataValid <= 1'b0;
    if (rdPend) begin
      if (rdDelay == 0) begin
        memRdDataValid <= 1'b1;
        memRdData      <= mem[rdLine];
        rdPend         <= 1'b0;
      end else rdDelay <= rdDelay - 1;
    end
    if (rstN && memRdValid && memRdReady) begin
      rdPend  <= 1'b1;
      rdDelay <= 1;
      rdLine  <= memAddr[8:6];
      rdCount <= rdCount + 1;
    end
    if (rstN && memWrValid && memWrReady) begin
      mem[memAddr[8:6]] <= memWrData;
      wrCount <= wrCount + 1;
    end
    if (memRdValid && memWrValid) overlap <= overlap + 1;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] mkAddr(input int line, input int chunk, input int skew);
    return 40'(line * 64 + chunk * 16 + skew);
  endfunction

  // Drive one device write; check the error flag against R9.
  task automatic doWrite(input logic [39:0] addr, input bit sz, input bit strm,
                         input logic [255:0] data);
    bit ok;
    int nBytes, off, ln;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = addr; wrSize = sz; wrStream = strm; wrData = data;
    #1;
    while (!wrReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    ok = (addr[3:0] == 4'd0) && (int'(addr[5:4]) + int'(sz) <= 3);
    check(wrErr == !ok, "R9", "error flag after write", 512'(wrErr), 512'(!ok));
    if (ok) begin
      nBytes = sz ? 32 : 16;
      off = int'(addr[5:0]);
      ln  = int'(addr[8:6]);
      for (int i = 0; i < nBytes; i++) expMem[ln][(off + i) * 8 +: 8] = data[i * 8 +: 8];
    end
  endtask

  task automatic pulseFlush();
    @(negedge clk); flushReq = 1'b1;
    @(negedge clk); flushReq = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [255:0] rndData();
    logic [255:0] d;
    for (int w = 0; w < 8; w++) d[w * 32 +: 32] = $urandom;
    return d;
  endfunction

  int rd0, wr0;

  initial begin
    void'($urandom(32'h5eed));
    for (int l = 0; l < NLINES; l++) begin
      for (int w = 0; w < 16; w++) mem[l][w * 32 +: 32] = $urandom;
      expMem[l] = mem[l];
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(wrReady == 1'b1, "R1", "wrReady after reset", 512'(wrReady), 512'(1));
    check(!memRdValid && !memWrValid && !wrErr, "R1", "no requests after reset",
          512'({memRdValid, memWrValid, wrErr}), 512'(0));

    // R7: flush with empty buffer is silent
    rd0 = rdCount; wr0 = wrCount;
    pulseFlush(); settle(10);
    check(rdCount == rd0 && wrCount == wr0, "R7", "empty flush traffic",
          512'(rdCount + wrCount), 512'(rd0 + wr0));

    // R3/R12: four streaming chunks fill line 1, one write, no read
    rd0 = rdCount; wr0 = wrCount;
    for (int c = 0; c < 4; c++) doWrite(mkAddr(1, c, 0), 1'b0, 1'b1, rndData());
    settle(30);
    check(rdCount == rd0 && wrCount == wr0 + 1, "R3", "full line 16B traffic",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd0, 32'd1}));
    check(mem[1] == expMem[1], "R12", "line 1 contents", mem[1], expMem[1]);

    // R3: two 32-byte streaming writes fill line 2
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(2, 2, 0), 1'b1, 1'b1, rndData());
    doWrite(mkAddr(2, 0, 0), 1'b1, 1'b1, rndData());
    settle(30);
    check(rdCount == rd0 && wrCount == wr0 + 1, "R3", "full line 32B traffic",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd0, 32'd1}));
    check(mem[2] == expMem[2], "R12", "line 2 contents", mem[2], expMem[2]);

    // R2 then R7: held partial line, then explicit flush
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(3, 1, 0), 1'b0, 1'b1, rndData());
    settle(5);
    check(rdCount == rd0 && wrCount == wr0 && mem[3] != expMem[3], "R2",
          "streaming partial held", 512'(wrCount - wr0), 512'(0));
    pulseFlush(); settle(30);
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1, "R7", "flush read-merge-write",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd1, 32'd1}));
    check(mem[3] == expMem[3], "R7", "line 3 merged", mem[3], expMem[3]);

    // R4/R10: consistent partial write completes at once, stalls device
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(4, 2, 0), 1'b0, 1'b0, rndData());
    check(memRdValid && !wrReady, "R10", "stall during consistent merge",
          512'({memRdValid, wrReady}), 512'({1'b1, 1'b0}));
    settle(30);
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1, "R4", "consistent traffic",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd1, 32'd1}));
    check(mem[4] == expMem[4], "R4", "line 4 merged", mem[4], expMem[4]);

    // R5: streaming then consistent on same line, one RMW
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(5, 0, 0), 1'b0, 1'b1, rndData());
    doWrite(mkAddr(5, 2, 0), 1'b1, 1'b0, rndData());
    settle(30);
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1, "R5", "joined RMW traffic",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd1, 32'd1}));
    check(mem[5] == expMem[5], "R5", "line 5 merged", mem[5], expMem[5]);

    // R6: streaming to another line evicts line 6 first
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(6, 3, 0), 1'b0, 1'b1, rndData());
    doWrite(mkAddr(7, 0, 0), 1'b1, 1'b1, rndData());
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1, "R6", "eviction before accept",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd1, 32'd1}));
    check(mem[6] == expMem[6], "R6", "line 6 evicted", mem[6], expMem[6]);

    // R8: line 7 held until the idle limit, then flushed
    rd0 = rdCount; wr0 = wrCount;
    settle(IDLE_LIMIT - 6);
    check(wrCount == wr0 && !memRdValid, "R8", "held before idle limit",
          512'(wrCount - wr0), 512'(0));
    settle(40);
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1, "R8", "timeout flush traffic",
          512'({rdCount - rd0, wrCount - wr0}), 512'({32'd1, 32'd1}));
    check(mem[7] == expMem[7], "R8", "line 7 after timeout", mem[7], expMem[7]);

    // R9: misaligned and line-crossing requests
    rd0 = rdCount; wr0 = wrCount;
    doWrite(mkAddr(0, 1, 8), 1'b0, 1'b1, rndData());
    doWrite(mkAddr(0, 3, 0), 1'b1, 1'b0, rndData());
    pulseFlush(); settle(20);
    check(rdCount == rd0 && wrCount == wr0 && mem[0] == expMem[0], "R9",
          "dropped writes leave memory", mem[0], expMem[0]);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int ln, ck, sk;
      bit sz, st;
      ln = $urandom_range(0, NLINES - 1);
      ck = $urandom_range(0, 3);
      sz = 1'($urandom_range(0, 1));
      st = 1'($urandom_range(0, 1));
      sk = ($urandom_range(0, 7) == 0) ? 4 : 0;
      doWrite(mkAddr(ln, ck, sk), sz, st, rndData());
      if ($urandom_range(0, 15) == 0) pulseFlush();
      settle($urandom_range(0, 3));
    end
    pulseFlush(); settle(60);
    for (int l = 0; l < NLINES; l++)
      check(mem[l] == expMem[l], "R12", $sformatf("random line %0d", l), mem[l], expMem[l]);
    check(overlap == 0, "R11", "read and write never together", 512'(overlap), 512'(0));

    done = 1'b1;
    summary();
  end

endmodule